// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block gives each side of a two-port memory a way to signal the other side. Each side has its own address, chip enable, read/write select, output enable and data lines. Two reserved words at the top of the address space act as mailboxes:

- The highest address (all ones) is the inbox of the right side.
- The address one below it is the inbox of the left side.

A write by the far side into an inbox pulls the owning side's active-low interrupt flag low. A read cycle by the owning side on its own inbox releases the flag. No separate interrupt registers are needed.

The two mailbox words are modelled as real storage, so a message written with the interrupt can be read back. Any read of another address returns zero. The general array, semaphores and busy arbitration are outside this block.

All activity is sampled on the rising clock edge. Flags and read data are registered, so they change at the edge that samples the access.

Signal encodings used throughout:

- Chip enable: active low.
- `*_rw`: 1 selects a read, 0 selects a write.
- Output enable: active low.

Access types:

- A write cycle is CE low with RW low.
- A read cycle is CE low, RW high and OE low.

Top module: `dpram_mailbox_irq`

## Requirements
- R1: A left write cycle to the all-ones address drives `r_int_n` low from the next clock edge onward.
- R2: A right read cycle (CE low, RW high, OE low) to the all-ones address drives `r_int_n` high at the next edge. A right access there with OE high does not clear it.
- R3: A right write cycle to the all-ones-minus-one address drives `l_int_n` low at the next edge.
- R4: A left read cycle (CE low, RW high, OE low) to the all-ones-minus-one address drives `l_int_n` high at the next edge.
- R5: When a set and a clear of the same flag fall in the same cycle, the flag ends low (set wins).
- R6: All other activity leaves both flags unchanged. This covers accesses with CE high, reads by the far side, writes by the owning side, and any other address.
- R7: During reset both flags are high, both mailbox words are zero and both read-data outputs are zero.
- R8: Either side's write cycle stores its data in the addressed mailbox word. When both sides write the same mailbox word in one cycle, the left data is kept.
- R9: A read cycle loads that side's read-data output at the next edge. It loads the addressed mailbox word as it was before that edge, or zero for any non-mailbox address. Without a read cycle, the read-data output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_addr | input | AW | Left address |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_int_n | output | 1 | Left interrupt flag, active low |
| r_addr | input | AW | Right address |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_int_n | output | 1 | Right interrupt flag, active low |

## Verification
Setting a flag and clearing that same flag can land on one edge: the far side writes the inbox while the owner reads it. Directed cycles force this pairing for both inboxes and judge that the flag is low afterwards. Random traffic, heavily biased toward the two mailbox addresses, also produces the collision repeatedly. A cycle-by-cycle model in the bench predicts each flag and read word from the requirements. The same traffic also exercises a same-word write racing a read, where the read must return the old contents.

// File: rtl/dpram_mailbox_irq.sv
module dpram_mailbox_irq #(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_ce_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_int_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_ce_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_int_n
);

  localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
  localparam logic [AW-1:0] L_BOX = R_BOX - AW'(1);

  logic [DW-1:0] rbox_q, lbox_q;
  logic          past_ok;

  wire l_wr = !l_ce_n && !l_rw;
  wire r_wr = !r_ce_n && !r_rw;
  wire l_rd = !l_ce_n && l_rw && !l_oe_n;
  wire r_rd = !r_ce_n && r_rw && !r_oe_n;

  wire l_at_r = l_addr == R_BOX;
  wire l_at_l = l_addr == L_BOX;
  wire r_at_r = r_addr == R_BOX;
  wire r_at_l = r_addr == L_BOX;

  wire set_r = l_wr && l_at_r;
  wire clr_r = r_rd && r_at_r;
  wire set_l = r_wr && r_at_l;
  wire clr_l = l_rd && l_at_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_int_n <= 1'b1;
      r_int_n <= 1'b1;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (set_r)      r_int_n <= 1'b0;
      else if (clr_r) r_int_n <= 1'b1;
      if (set_l)      l_int_n <= 1'b0;
      else if (clr_l) l_int_n <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbox_q <= '0;
      lbox_q <= '0;
    end else begin
      if (l_wr && l_at_r)      rbox_q <= l_wdata;
      else if (r_wr && r_at_r) rbox_q <= r_wdata;
      if (l_wr && l_at_l)      lbox_q <= l_wdata;
      else if (r_wr && r_at_l) lbox_q <= r_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= l_at_r ? rbox_q : (l_at_l ? lbox_q : '0);
      if (r_rd) r_rdata <= r_at_r ? rbox_q : (r_at_l ? lbox_q : '0);
    end
  end

  a_r1_left_write_sets_right: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && set_r |=> !r_int_n);
  a_r2_right_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && clr_r && !set_r |=> r_int_n);
  a_r3_right_write_sets_left: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && set_l |=> !l_int_n);
  a_r4_left_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && clr_l && !set_l |=> l_int_n);
  a_r6_right_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !set_r && !clr_r |=> $stable(r_int_n));
  a_r6_left_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !set_l && !clr_l |=> $stable(l_int_n));
  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !l_rd && !r_rd |=> $stable(l_rdata) && $stable(r_rdata));
  a_r9_left_reads_old_word: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && l_rd && l_at_r |=> l_rdata == $past(rbox_q));

endmodule

// File: tb/dpram_mailbox_irq_tb_top.sv
module dpram_mailbox_irq_tb_top;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam logic [AW-1:0] RB = {AW{1'b1}};
  localparam logic [AW-1:0] LB = RB - AW'(1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_ce_n = 1'b1, r_ce_n = 1'b1, l_rw = 1'b1, r_rw = 1'b1, l_oe_n = 1'b1, r_oe_n = 1'b1;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int checks = 0, fails = 0;
  bit done = 0;
  logic e_l = 1'b1, e_r = 1'b1;
  logic [DW-1:0] e_rbox = '0, e_lbox = '0, e_lrd = '0, e_rrd = '0;

  always #4 clk = ~clk;

  dpram_mailbox_irq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_addr(l_addr), .l_ce_n(l_ce_n), .l_rw(l_rw), .l_oe_n(l_oe_n), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_int_n(l_int_n),
    .r_addr(r_addr), .r_ce_n(r_ce_n), .r_rw(r_rw), .r_oe_n(r_oe_n), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_int_n(r_int_n));

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return (a == RB) ? e_rbox : ((a == LB) ? e_lbox : '0);
  endfunction

  task automatic check_all();
    chk("R1/R2/R5/R6 r_int_n", DW'(r_int_n), DW'(e_r));
    chk("R3/R4/R5/R6 l_int_n", DW'(l_int_n), DW'(e_l));
    chk("R8/R9 l_rdata", l_rdata, e_lrd);
    chk("R8/R9 r_rdata", r_rdata, e_rrd);
  endtask

  // drives one cycle (called at a negedge), updates the model, checks at next negedge
  task automatic cyc(input logic [AW-1:0] la, input logic lce, input logic lrw, input logic loe,
                     input logic [DW-1:0] lwd,
                     input logic [AW-1:0] ra, input logic rce, input logic rrw, input logic roe,
                     input logic [DW-1:0] rwd);
    logic lw, rw, lr, rr;
    l_addr = la; l_ce_n = lce; l_rw = lrw; l_oe_n = loe; l_wdata = lwd;
    r_addr = ra; r_ce_n = rce; r_rw = rrw; r_oe_n = roe; r_wdata = rwd;
    lw = !lce && !lrw; rw = !rce && !rrw;
    lr = !lce && lrw && !loe; rr = !rce && rrw && !roe;
    if (lr) e_lrd = word_at(la);
    if (rr) e_rrd = word_at(ra);
    if (lw && la == RB) e_r = 1'b0; else if (rr && ra == RB) e_r = 1'b1;
    if (rw && ra == LB) e_l = 1'b0; else if (lr && la == LB) e_l = 1'b1;
    if (lw && la == RB) e_rbox = lwd; else if (rw && ra == RB) e_rbox = rwd;
    if (lw && la == LB) e_lbox = lwd; else if (rw && ra == LB) e_lbox = rwd;
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [AW-1:0] la, ra;
    logic [DW-1:0] tmp;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 l_int_n", DW'(l_int_n), DW'(1'b1));
    chk("R7 r_int_n", DW'(r_int_n), DW'(1'b1));
    chk("R7 l_rdata", l_rdata, '0);
    chk("R7 r_rdata", r_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: left write to right inbox
    cyc(RB, 0, 0, 1, 16'hA5A5, '0, 1, 1, 1, '0);
    chk("R1 r_int_n low", DW'(r_int_n), DW'(1'b0));
    // R2: right access with OE high does not clear
    cyc('0, 1, 1, 1, '0, RB, 0, 1, 1, '0);
    chk("R2 oe high keeps r_int_n", DW'(r_int_n), DW'(1'b0));
    // R6: left reads right inbox, right writes it: no flag change
    cyc(RB, 0, 1, 0, '0, RB, 0, 0, 1, 16'h1234);
    chk("R6 r_int_n unchanged", DW'(r_int_n), DW'(1'b0));
    chk("R8 left reads stored word", l_rdata, 16'hA5A5);
    // R2: right read clears, returns R6 write
    cyc('0, 1, 1, 1, '0, RB, 0, 1, 0, '0);
    chk("R2 r_int_n cleared", DW'(r_int_n), DW'(1'b1));
    chk("R8 right read data", r_rdata, 16'h1234);
    // R3 then R4
    cyc('0, 1, 1, 1, '0, LB, 0, 0, 1, 16'h0F0F);
    chk("R3 l_int_n low", DW'(l_int_n), DW'(1'b0));
    cyc(LB, 0, 1, 0, '0, '0, 1, 1, 1, '0);
    chk("R4 l_int_n cleared", DW'(l_int_n), DW'(1'b1));
    chk("R9 left reads mailbox", l_rdata, 16'h0F0F);
    // R5: set and clear together on both flags
    cyc(LB, 0, 1, 0, '0, LB, 0, 0, 1, 16'h7777);
    chk("R5 left set wins", DW'(l_int_n), DW'(1'b0));
    chk("R9 old word on read-write race", l_rdata, 16'h0F0F);
    cyc(RB, 0, 0, 1, 16'h3333, RB, 0, 1, 0, '0);
    chk("R5 right set wins", DW'(r_int_n), DW'(1'b0));
    chk("R9 right old word", r_rdata, 16'h1234);
    // R8: both write same word, left kept
    cyc(RB, 0, 0, 1, 16'hBEEF, RB, 0, 0, 1, 16'hDEAD);
    cyc(RB, 0, 1, 0, '0, '0, 1, 1, 1, '0);
    chk("R8 left wins same-word write", l_rdata, 16'hBEEF);
    // R6: CE high write, other address
    cyc(LB, 1, 1, 0, '0, 13'h0100, 0, 0, 1, 16'h1111);
    chk("R6 l_int_n unchanged", DW'(l_int_n), DW'(1'b0));
    // R9: non-mailbox read returns zero
    cyc(13'h0100, 0, 1, 0, '0, '0, 1, 1, 1, '0);
    chk("R9 other address zero", l_rdata, '0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      tmp = DW'($urandom);
      case ($urandom_range(3))
        0: la = RB; 1: la = LB; 2: la = AW'($urandom); default: la = ($urandom_range(1)) ? RB : LB;
      endcase
      case ($urandom_range(3))
        0: ra = RB; 1: ra = LB; 2: ra = AW'($urandom); default: ra = ($urandom_range(1)) ? RB : LB;
      endcase
      cyc(la, ($urandom_range(3) == 0), $urandom_range(1), ($urandom_range(3) == 0), tmp,
          ra, ($urandom_range(3) == 0), $urandom_range(1), ($urandom_range(3) == 0), DW'($urandom));
    end
    finish_run();
  end
endmodule